// File: doc/BRIEF.md
# Neighbour Workload Smoothing Router

The router sits between a stream of multiply tasks and an array of per-PE task queues. Every incoming task names its home PE, the PE that owns the output row. The router keeps a live count of pending tasks for each queue. It sends the task to the least occupied queue within a hop window around the home PE. The window width is chosen at run time. This decision is made before the task enters any queue, so a busy PE hands work to an idle nearby PE instead of building up a backlog.

Each push carries the chosen queue index and the home-PE index together with the operand pair and the row index. A helper PE can then send its partial sum back to the owner's accumulator. The PEs report each task they take from their queues with a per-queue pop strobe, and the router uses these strobes to keep its counts current.

The input is a valid/ready stream. A task is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is a combinational function of the queue counts, `in_home` and `cfg_hops`, and it is low only when every queue in the task's window is full. While `in_valid` is high and `in_ready` is low, the source must hold the task unchanged. The queue side has no back-pressure: a push always lands, because the router never pushes into a full queue.

Top module: `nbr_smooth_router`

## Requirements
- R1: After reset every pending count is zero. The first task is therefore pushed to its home queue (`out_dest == in_home`).
- R2: A queue's count rises by one on a push, falls by one on a pop, and stays the same when both happen in the same cycle. A pop strobe on an empty queue is ignored.
- R3: The destination is a queue with the lowest count among the indices i where |i - in_home| <= cfg_hops. Indices below 0 or above NPE-1 are dropped from the window, and the window does not wrap around the array.
- R4: On equal counts the home queue wins. Among neighbours with equal counts, the lower index wins.
- R5: `cfg_hops` may change from task to task. A value of 0 keeps every task at home, and values 1, 2 and 3 widen the window to that many hops. Any value above MAX_HOP is treated as MAX_HOP.
- R6: On an accepted task `out_push` is one-hot, with bit `out_dest` set. `out_home` equals `in_home`, and `out_row`, `out_a` and `out_b` equal the inputs.
- R7: A queue never holds more than DEPTH tasks. `in_ready` is high exactly when the chosen queue holds fewer than DEPTH tasks. When `in_ready` is low, `out_push` is all zero. A pop in the same cycle does not make room for a push in that cycle.
- R8: When `in_valid` is low, `out_push` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hops | input | $clog2(MAX_HOP+1) | Window half-width in hops |
| in_valid | input | 1 | Incoming task valid |
| in_ready | output | 1 | Router can take the task |
| in_home | input | $clog2(NPE) | Home PE of the task |
| in_row | input | RW | Row index of the task |
| in_a | input | DW | First operand |
| in_b | input | DW | Second operand |
| q_pop | input | NPE | Per-queue pop strobe from the PEs |
| out_push | output | NPE | One-hot push strobe to the queues |
| out_dest | output | $clog2(NPE) | Queue chosen for the task |
| out_home | output | $clog2(NPE) | Home-PE tag carried with the task |
| out_row | output | RW | Row index carried with the task |
| out_a | output | DW | First operand carried |
| out_b | output | DW | Second operand carried |

## Verification
The bench uses the defaults NPE=8, DEPTH=4 and MAX_HOP=3. With these values every hop setting from 0 to 3 can be tried. A window of three hops can also be anchored at queue 0 and at queue 7, which exercises both array edges. The shallow depth lets a whole window fill up within a few tasks, so the stall with `in_ready` low is reached quickly. Counts are never observed directly. They are inferred from where later tasks land and from when the stall appears, including after a push and pop in the same cycle and after a pop on an empty queue.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  // distance in PE indices between two positions
  function automatic int hop_span(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // effective window width after limiting to the built maximum
  function automatic int limit_hops(input int req, input int max_hop);
    return (req > max_hop) ? max_hop : req;
  endfunction
endpackage

// File: rtl/nsr_occ_counter.sv
module nsr_occ_counter #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic do_push, do_pop;
  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && (cnt != FULL);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (do_push && !do_pop) cnt <= cnt + 1'b1;
    else if (do_pop && !do_push) cnt <= cnt - 1'b1;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  p_hold_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && cnt != '0 && cnt != FULL) |=> cnt == $past(cnt));
  p_inc_on_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt != FULL) |=> cnt == $past(cnt) + 1'b1);
  p_empty_pop_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/nsr_window_select.sv
module nsr_window_select #(
  parameter int NPE     = 8,
  parameter int DEPTH   = 4,
  parameter int MAX_HOP = 3,
  localparam int IW = $clog2(NPE),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(MAX_HOP + 1)
) (
  input  logic [NPE-1:0][CW-1:0] occ,
  input  logic [IW-1:0]          home,
  input  logic [HW-1:0]          hops,
  output logic [IW-1:0]          best_idx,
  output logic [CW-1:0]          best_cnt
);
  int eff;
  assign eff = nsr_pkg::limit_hops(int'(hops), MAX_HOP);

  // scan from lowest to highest index; strict compare keeps home, then lower index
  always_comb begin
    best_idx = home;
    best_cnt = occ[home];
    for (int d = -MAX_HOP; d <= MAX_HOP; d++) begin
      if (d != 0 && (int'(home) + d) >= 0 && (int'(home) + d) < NPE &&
          nsr_pkg::hop_span(d, 0) <= eff) begin
        if (occ[IW'(int'(home) + d)] < best_cnt) begin
          best_cnt = occ[IW'(int'(home) + d)];
          best_idx = IW'(int'(home) + d);
        end
      end
    end
  end
endmodule

// File: rtl/nbr_smooth_router.sv
module nbr_smooth_router #(
  parameter int NPE     = 8,
  parameter int DEPTH   = 4,
  parameter int MAX_HOP = 3,
  parameter int RW      = 16,
  parameter int DW      = 16,
  localparam int IW = $clog2(NPE),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(MAX_HOP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  cfg_hops,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IW-1:0]  in_home,
  input  logic [RW-1:0]  in_row,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  input  logic [NPE-1:0] q_pop,
  output logic [NPE-1:0] out_push,
  output logic [IW-1:0]  out_dest,
  output logic [IW-1:0]  out_home,
  output logic [RW-1:0]  out_row,
  output logic [DW-1:0]  out_a,
  output logic [DW-1:0]  out_b
);
  logic [NPE-1:0][CW-1:0] occ;
  logic [IW-1:0]          best_idx;
  logic [CW-1:0]          best_cnt;
  logic                   accept;

  for (genvar g = 0; g < NPE; g++) begin : g_occ
    nsr_occ_counter #(.DEPTH(DEPTH)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .push (out_push[g]),
      .pop  (q_pop[g]),
      .cnt  (occ[g])
    );
  end

  nsr_window_select #(.NPE(NPE), .DEPTH(DEPTH), .MAX_HOP(MAX_HOP)) u_sel (
    .occ     (occ),
    .home    (in_home),
    .hops    (cfg_hops),
    .best_idx(best_idx),
    .best_cnt(best_cnt)
  );

  assign in_ready = (best_cnt < CW'(DEPTH));
  assign accept   = in_valid && in_ready;

  always_comb begin
    out_push = '0;
    if (accept) out_push[best_idx] = 1'b1;
  end

  assign out_dest = best_idx;
  assign out_home = in_home;
  assign out_row  = in_row;
  assign out_a    = in_a;
  assign out_b    = in_b;

  p_push_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_push));
  p_push_at_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_push) |-> out_push[out_dest]);
  p_dest_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_push) |-> (nsr_pkg::hop_span(int'(out_dest), int'(in_home)) <=
                     nsr_pkg::limit_hops(int'(cfg_hops), MAX_HOP)));
  p_idle_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (out_push == '0));
endmodule

// File: tb/tb_nbr_smooth_router.sv
module tb_nbr_smooth_router;
  localparam int NPE = 8, DEPTH = 4, MAX_HOP = 3, RW = 16, DW = 16;
  localparam int IW = $clog2(NPE), HW = $clog2(MAX_HOP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] cfg_hops = '0;
  logic in_valid = 1'b0, in_ready;
  logic [IW-1:0] in_home = '0;
  logic [RW-1:0] in_row = '0;
  logic [DW-1:0] in_a = '0, in_b = '0;
  logic [NPE-1:0] q_pop = '0, out_push;
  logic [IW-1:0] out_dest, out_home;
  logic [RW-1:0] out_row;
  logic [DW-1:0] out_a, out_b;

  int checks = 0, errors = 0;
  int model[NPE];

  nbr_smooth_router #(.NPE(NPE), .DEPTH(DEPTH), .MAX_HOP(MAX_HOP), .RW(RW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_hops(cfg_hops), .in_valid(in_valid), .in_ready(in_ready),
    .in_home(in_home), .in_row(in_row), .in_a(in_a), .in_b(in_b), .q_pop(q_pop),
    .out_push(out_push), .out_dest(out_dest), .out_home(out_home), .out_row(out_row),
    .out_a(out_a), .out_b(out_b));

  always #10 clk = ~clk;

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, update model after it
  task automatic step(input bit v, input int home, input int hops, input logic [NPE-1:0] pops,
                      input string req);
    int d, lim;
    bit rdy;
    in_valid = v; in_home = IW'(home); cfg_hops = HW'(hops); q_pop = pops;
    in_row = RW'(home * 37 + hops + 5); in_a = DW'(home + 100); in_b = DW'(hops + 200);
    lim = (hops > MAX_HOP) ? MAX_HOP : hops;
    d = home;
    for (int k = home - lim; k <= home + lim; k++)
      if (k >= 0 && k < NPE && k != home && model[k] < model[d]) d = k;
    rdy = model[d] < DEPTH;
    #5;
    if (!v) chk({req, " idle push"}, int'(out_push), 0);
    else begin
      chk({req, " ready"}, int'(in_ready), int'(rdy));
      chk({req, " push"}, int'(out_push), rdy ? (1 << d) : 0);
      if (rdy) begin
        chk({req, " dest"}, int'(out_dest), d);
        chk({req, " home tag R6"}, int'(out_home), home);
        chk({req, " row R6"}, int'(out_row), home * 37 + hops + 5);
        chk({req, " operands R6"}, int'({out_a, out_b}), int'({DW'(home + 100), DW'(hops + 200)}));
      end
    end
    @(posedge clk);
    for (int k = 0; k < NPE; k++) begin
      bit pu;
      pu = v && rdy && (k == d);
      if (pu && !(pops[k] && model[k] > 0)) model[k]++;
      else if (!pu && pops[k] && model[k] > 0) model[k]--;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH; i++) step(1'b0, 0, 0, '1, "drain R8");
  endtask

  task automatic t_reset();
    step(1'b0, 0, 3, '0, "R1 R8");
    step(1'b1, 5, 3, '0, "R1 R4");
    drain();
  endtask

  task automatic t_hop_zero();
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 2, 0, '0, "R5 R7");
    step(1'b1, 2, 0, 8'h04, "R7 pop no room");
    drain();
  endtask

  task automatic t_tie_order();
    for (int i = 0; i < 9; i++) step(1'b1, 4, 1, '0, "R4");
    drain();
  endtask

  task automatic t_edges();
    for (int i = 0; i < 4 * DEPTH + 1; i++) step(1'b1, 0, 3, '0, "R3 low edge");
    drain();
    for (int i = 0; i < 4 * DEPTH + 1; i++) step(1'b1, 7, 3, '0, "R3 high edge");
    drain();
  endtask

  task automatic t_hop_limit();
    for (int i = 0; i < 5 * DEPTH + 1; i++) step(1'b1, 4, 2, '0, "R3 hop2");
    step(1'b1, 1, 0, '0, "R3 outside window");
    step(1'b1, 4, 3, '0, "R5 widen");
    drain();
  endtask

  task automatic t_push_pop_same();
    step(1'b1, 1, 0, '0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1, 0, 8'h02, "R2 both");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1, 0, '0, "R2 fill");
    drain();
  endtask

  task automatic t_pop_empty();
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 8'h40, "R2 empty pop");
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 6, 0, '0, "R2 after empty pop");
    drain();
  endtask

  initial begin
    for (int k = 0; k < NPE; k++) model[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hop_zero();
    t_tie_order();
    t_edges();
    t_hop_limit();
    t_push_pop_same();
    t_pop_empty();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule